// File: doc/BRIEF.md
# Transmit Test-Symbol Generator

This block produces the line symbols a gigabit copper transceiver sends while a transmitter test is running. On every edge of the symbol clock it emits one five-level symbol, one of -2, -1, 0, +1 or +2, coded as a signed 3-bit value. The same symbol goes to all four lane outputs in the same symbol period. A 3-bit mode input chooses between quiet output (symbol 0), a strict alternation of +2 and -2, and a pseudo-random stream.

The pseudo-random stream comes from an 11-stage maximal-length shift register that steps once per symbol. Three bits are derived from its stages. Together they form a 3-bit index into an eight-entry level table, and the table gives the output symbol. The register is held at its all-ones seed whenever the scrambler mode is not selected. Each entry into that mode therefore starts the same sequence from its beginning.

Top module: `txtest_symgen`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every lane outputs 0 and the shift register holds the all-ones seed.
- R2: Mode codes are: 3'b000 quiet, 3'b011 alternating, 3'b100 scrambler. Every other code behaves as quiet. Quiet mode outputs symbol 0.
- R3: The output is registered. The symbol seen after a clock edge is determined by the mode sampled at that edge.
- R4: In alternating mode the first symbol after entry is +2, and each later symbol is the negation of the one before. Leaving the mode and entering again restarts with +2.
- R5: In scrambler mode the register shifts one place toward bit 10 at each edge. The new bit 0 is bit 8 XOR bit 10.
- R6: The index bits are x0 = s[0], x1 = s[1] XOR s[4] and x2 = s[2] XOR s[6], taken from the register state before the edge.
- R7: The index {x2,x1,x0} from 000 up to 111 maps to 0, +1, +2, -1, 0, +1, -2, -1.
- R8: When not in scrambler mode the register reloads the all-ones seed. The first scrambler symbol after entry is therefore +1 (index 001).
- R9: The scrambler output repeats with a period of 2047 symbols, and the register never reaches all zeros.
- R10: All four lanes carry the same symbol. Lane k occupies bits [3k+2:3k] of the output bus, in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Test mode select |
| sym_o | output | 12 | Four 3-bit signed lane symbols, lane 0 in the low bits |

## Verification
The bench goes after the mode boundaries. A design that fails to reload the seed on leaving scrambler mode gives a different first symbol on re-entry. A design that fails to reset the alternation phase can start with -2. It also tries the unused mode codes, which a careless decoder might route to one of the test patterns. A run of more than 2047 scrambler symbols exposes wrong feedback taps or index bits, because the stream then diverges from the expected sequence or fails to repeat at 2047.

// File: rtl/txtest_pkg.sv
package txtest_pkg;
  localparam int unsigned SYM_W   = 3;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned SCR_W   = 11;
  localparam int unsigned TAP_A   = 8;
  localparam int unsigned TAP_B   = 10;
  localparam int unsigned X1_TAP  = 4;
  localparam int unsigned X2_TAP  = 6;

  localparam logic [MODE_W-1:0] MODE_QUIET = 3'b000;
  localparam logic [MODE_W-1:0] MODE_ALT   = 3'b011;
  localparam logic [MODE_W-1:0] MODE_SCR   = 3'b100;

  typedef logic signed [SYM_W-1:0] qsym_t;

  localparam qsym_t SYM_ZERO = 3'sd0;
  localparam qsym_t SYM_POS2 = 3'sd2;
  localparam qsym_t SYM_NEG2 = -3'sd2;

  // Five-level mapping of the 3-bit index.
  function automatic qsym_t level_of(input logic [2:0] idx);
    qsym_t lv;
    case (idx)
      3'd0:    lv = 3'sd0;
      3'd1:    lv = 3'sd1;
      3'd2:    lv = 3'sd2;
      3'd3:    lv = -3'sd1;
      3'd4:    lv = 3'sd0;
      3'd5:    lv = 3'sd1;
      3'd6:    lv = -3'sd2;
      default: lv = -3'sd1;
    endcase
    return lv;
  endfunction
endpackage

// File: rtl/txtest_lfsr.sv
module txtest_lfsr #(
  parameter int unsigned WIDTH = txtest_pkg::SCR_W,
  parameter int unsigned TAP_A = txtest_pkg::TAP_A,
  parameter int unsigned TAP_B = txtest_pkg::TAP_B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [WIDTH-1:0] state_o
);
  localparam logic [WIDTH-1:0] SEED = {WIDTH{1'b1}};

  logic [WIDTH-1:0] state_q, state_d;

  always_comb begin
    if (advance_i) begin
      state_d = {state_q[WIDTH-2:0], state_q[TAP_A] ^ state_q[TAP_B]};
    end else begin
      state_d = SEED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/txtest_xmap.sv
module txtest_xmap
  import txtest_pkg::*;
#(
  parameter int unsigned WIDTH = SCR_W
) (
  input  logic [WIDTH-1:0] state_i,
  output qsym_t            sym_o
);
  logic [2:0] idx;

  always_comb begin
    idx[0] = state_i[0];
    idx[1] = state_i[1] ^ state_i[X1_TAP];
    idx[2] = state_i[2] ^ state_i[X2_TAP];
    sym_o  = level_of(idx);
  end
endmodule

// File: rtl/txtest_altsrc.sv
module txtest_altsrc
  import txtest_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  output qsym_t sym_o
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = active_i ? ~phase_q : 1'b0;
    sym_o   = phase_q ? SYM_NEG2 : SYM_POS2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/txtest_symgen.sv
module txtest_symgen
  import txtest_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [MODE_W-1:0]            mode_i,
  output logic [NUM_LANES*SYM_W-1:0]   sym_o
);
  logic             scr_sel, alt_sel;
  logic [SCR_W-1:0] lfsr_q;
  qsym_t            scr_sym, alt_sym, sym_d;

  assign scr_sel = (mode_i == MODE_SCR);
  assign alt_sel = (mode_i == MODE_ALT);

  txtest_lfsr #(.WIDTH(SCR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (scr_sel),
    .state_o   (lfsr_q)
  );

  txtest_xmap #(.WIDTH(SCR_W)) u_xmap (
    .state_i (lfsr_q),
    .sym_o   (scr_sym)
  );

  txtest_altsrc u_alt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (alt_sel),
    .sym_o    (alt_sym)
  );

  always_comb begin
    if (scr_sel)      sym_d = scr_sym;
    else if (alt_sel) sym_d = alt_sym;
    else              sym_d = SYM_ZERO;
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    qsym_t lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= SYM_ZERO;
      end else begin
        lane_q <= sym_d;
      end
    end
    assign sym_o[k*SYM_W +: SYM_W] = lane_q;
  end
endmodule

// File: rtl/txtest_symgen_chk.sv
module txtest_symgen_chk
  import txtest_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [MODE_W-1:0]          mode_i,
  input logic [NUM_LANES*SYM_W-1:0] sym_o,
  input logic [SCR_W-1:0]           lfsr_q
);
  qsym_t lane0;
  logic  lanes_same;

  always_comb begin
    lane0      = sym_o[SYM_W-1:0];
    lanes_same = 1'b1;
    for (int k = 1; k < NUM_LANES; k++) begin
      if (sym_o[k*SYM_W +: SYM_W] != sym_o[SYM_W-1:0]) lanes_same = 1'b0;
    end
  end

  p_lanes_same_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lanes_same);

  p_quiet_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_ALT && mode_i != MODE_SCR) |=> (lane0 == SYM_ZERO));

  p_alt_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ALT && $past(mode_i) == MODE_ALT) |=> (lane0 != $past(lane0)));

  p_alt_levels_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ALT) |=> (lane0 == SYM_POS2 || lane0 == SYM_NEG2));

  p_no_lockup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  p_seed_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_SCR) |=> (lfsr_q == {SCR_W{1'b1}}));

  p_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane0 >= -3'sd2));
endmodule

bind txtest_symgen txtest_symgen_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .sym_o  (sym_o),
  .lfsr_q (lfsr_q)
);

// File: tb/txtest_symgen_tb_top.sv
module txtest_symgen_tb_top;
  localparam int LANES = 4;
  localparam int LONG  = 2100;

  logic                clk_i = 1'b0;
  logic                rst_ni;
  logic [2:0]          mode_i;
  logic [LANES*3-1:0]  sym_o;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  logic [10:0]       m_lfsr;
  logic              m_phase;
  logic signed [2:0] got_seq [LONG];

  always #5 clk_i = ~clk_i;

  txtest_symgen #(.NUM_LANES(LANES)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .sym_o  (sym_o)
  );

  function automatic logic signed [2:0] ref_level(input logic [10:0] s);
    logic [2:0] ix;
    ix = {s[2] ^ s[6], s[1] ^ s[4], s[0]};
    case (ix)
      3'b000, 3'b100: return 3'sd0;
      3'b001, 3'b101: return 3'sd1;
      3'b010:         return 3'sd2;
      3'b110:         return -3'sd2;
      default:        return -3'sd1;
    endcase
  endfunction

  function automatic logic [10:0] ref_step(input logic [10:0] s);
    return {s[9:0], s[8] ^ s[10]};
  endfunction

  task automatic check(input string req, input logic signed [2:0] exp);
    for (int k = 0; k < LANES; k++) begin
      n_chk++;
      if ($signed(sym_o[k*3 +: 3]) != exp) begin
        n_fail++;
        $display("FAIL %s lane %0d: got %0d expected %0d", req, k,
                 $signed(sym_o[k*3 +: 3]), exp);
      end
    end
  endtask

  task automatic step(input logic [2:0] md, input string req);
    logic signed [2:0] exp;
    @(negedge clk_i);
    mode_i = md;
    if (md == 3'b100) begin
      exp    = ref_level(m_lfsr);
      m_lfsr = ref_step(m_lfsr);
    end else begin
      exp    = (md == 3'b011) ? (m_phase ? -3'sd2 : 3'sd2) : 3'sd0;
      m_lfsr = '1;
    end
    m_phase = (md == 3'b011) ? ~m_phase : 1'b0;
    @(posedge clk_i);
    #2;
    check(req, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [2:0]  md;
    seed    = 32'd20240611;
    void'($urandom(seed));
    rst_ni  = 1'b0;
    mode_i  = 3'b100;
    m_lfsr  = '1;
    m_phase = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", 3'sd0);
    rst_ni = 1'b1;

    // R2 quiet and unused codes
    step(3'b000, "R2");
    for (int c = 0; c < 8; c++) begin
      if (c != 3 && c != 4) step(3'(c), "R2");
    end
    // R4 alternation with restart
    for (int i = 0; i < 5; i++) step(3'b011, "R4");
    step(3'b111, "R2");
    for (int i = 0; i < 3; i++) step(3'b011, "R4");
    // R8 seed restart: first symbol is +1
    step(3'b100, "R8");
    for (int i = 0; i < 20; i++) step(3'b100, "R5 R6 R7");
    step(3'b011, "R3");
    step(3'b100, "R8");
    step(3'b100, "R5");

    // random mix
    for (int i = 0; i < 800; i++) begin
      case ($urandom % 6)
        0:       md = 3'b000;
        1, 2:    md = 3'b011;
        3, 4:    md = 3'b100;
        default: md = 3'($urandom % 8);
      endcase
      step(md, "R3 R10");
    end

    // R9 period
    step(3'b000, "R2");
    for (int i = 0; i < LONG; i++) begin
      step(3'b100, "R6 R7");
      got_seq[i] = $signed(sym_o[2:0]);
    end
    for (int i = 0; i < LONG - 2047; i++) begin
      n_chk++;
      if (got_seq[i] != got_seq[i+2047]) begin
        n_fail++;
        $display("FAIL R9 index %0d: got %0d expected %0d", i + 2047,
                 got_seq[i+2047], got_seq[i]);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule